// File: doc/BRIEF.md
# Joint BCH Syndrome and Parallel Root Search Unit

This unit serves a binary BCH decoder in two phases and uses one set of remainder registers and reduction networks for both. In the syndrome phase (`mode_syn` high) it takes a received word of `N` bits, `P` bits per beat. Each row keeps a running remainder of the word modulo a minimal polynomial. Each beat, the stored remainder is shifted by `x^P` and the new bits are folded in with a 1-bit adder per stage. After the last beat, one constant basis map per row turns each remainder into an odd-index syndrome. The even-index syndromes are squares of lower ones.

In the search phase (`mode_syn` low), the error-locator coefficients are loaded through an inverse basis map into the same registers. The unit then tests `P` candidate positions per cycle for `ceil(N/P)` cycles. Each row's register is multiplied by `x^P` modulo its minimal polynomial every cycle. A row that evaluates to zero raises a flag along with the bit position it stands for.

Flow control: `rx_ready` equals `mode_syn`, so data can only be back-pressured by leaving the syndrome phase. A beat is taken on a clock edge where `rx_valid` and `rx_ready` are both high. The syndrome and search outputs are strobes and have no back-pressure. A consumer must take `syn_out` while `syn_valid` is high, or before the next beat or search, because the registers are shared. If `N` is not a multiple of `P`, the leading `ceil(N/P)*P-N` bits of the first beat are forced to zero.

Top module: `jsc_unit`

## Requirements
- R1: After reset, `syn_valid`, `srch_valid` and `srch_flag` are all zero.
- R2: `rx_ready` equals `mode_syn`. A beat presented while `mode_syn` is low is ignored: it changes neither the syndromes nor the beat count. `srch_valid` is never high together with `rx_ready`.
- R3: Within a beat, `rx_bits[P-1]` carries the highest remaining power. Beat 0 carries coefficients N-1 down to N-P.
- R4: `syn_valid` is high for exactly one cycle. It is registered on the edge that takes the `ceil(N/P)`-th beat of a word, and it is low before that edge.
- R5: When `syn_valid` is high, slice `syn_out[(i-1)*M +: M]` equals R(α^i) for i = 1..2T. α is a root of the primitive polynomial `PRIM`; the default is x^4+x+1, with field elements as polynomial-basis bit vectors.
- R6: The first beat of each word clears the remainders. This holds after a finished word and after a search.
- R7: While `mode_syn` is high and no beat is taken, `syn_out` holds its value, and `lam_load` has no effect on it.
- R8: `lam_load` with `mode_syn` low loads Λ1..ΛT. Λj is in `lam_coef[j*M-1:(j-1)*M]` and Λ0 = 1. `srch_valid` is then high for exactly `ceil(N/P)` consecutive cycles, starting the cycle after the load.
- R9: In search cycle τ (τ = 0 first), row r = 1..P reports position N-r-Pτ in `srch_loc[(r-1)*LW +: LW]`. Its bit `srch_flag[r-1]` is 1 exactly when Λ(α^(r+Pτ)) = 0, that is when the row stands for an error position of the locator. Rows with r+Pτ > N report 0.
- R10: `lam_load` is ignored while `mode_syn` is high: no search starts.
- R11: A flag is raised only when `srch_valid` is high, and no more than T flags are raised in any one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_syn | input | 1 | 1 = syndrome phase, 0 = search phase |
| rx_valid | input | 1 | Received beat present |
| rx_ready | output | 1 | Beat accepted (equals `mode_syn`) |
| rx_bits | input | P | Received bits, highest power in the MSB |
| lam_load | input | 1 | Load locator coefficients and start a search |
| lam_coef | input | T*M | Λ1..ΛT, Λ1 in the low bits |
| syn_valid | output | 1 | Syndromes complete (one-cycle pulse) |
| syn_out | output | 2*T*M | S1..S2T, S1 in the low bits |
| srch_valid | output | 1 | Search cycle in progress |
| srch_flag | output | P | Per-row root flag |
| srch_loc | output | P*ceil(log2 N) | Per-row bit position |

## Verification
The bound checker watches the handshake and phase rules on every cycle. It checks that `syn_valid` is a single-cycle pulse and that the syndromes hold between beats. It also checks that search and data acceptance never overlap, that a search begins after a load and never runs past `ceil(N/P)` cycles, and that flags appear only during a search and never exceed T per cycle. Whether the syndrome values and the flagged positions are arithmetically correct can only be shown by the bench scenarios. These encode words of the default double-error code, add zero to two bit errors, and compare against a direct power-sum model and against the locator built from the known error positions.

// File: rtl/bch_pkg.sv
package bch_pkg;
  localparam int GW = 16;

  function automatic logic [GW-1:0] gf_mul(input logic [GW-1:0] a, input logic [GW-1:0] b,
                                           input int m, input int prim);
    logic [GW:0] r;
    logic [GW:0] pv;
    r  = '0;
    pv = (GW+1)'(prim);
    for (int i = GW-1; i >= 0; i--) begin
      if (i < m) begin
        r = r << 1;
        if (r[m]) r = r ^ pv;
        if (b[i]) r = r ^ {1'b0, a};
      end
    end
    return r[GW-1:0];
  endfunction

  function automatic logic [GW-1:0] gf_pow(input int e, input int m, input int prim);
    logic [GW-1:0] r;
    int n;
    int ee;
    n  = (1 << m) - 1;
    ee = e % n;
    r  = GW'(1);
    for (int i = 0; i < ee; i++) r = gf_mul(r, GW'(2), m, prim);
    return r;
  endfunction

  // binary minimal polynomial of alpha^j, bit i = coefficient of x^i
  function automatic logic [GW:0] minpoly(input int j, input int m, input int prim);
    logic [GW-1:0] c [GW+1];
    logic [GW-1:0] beta;
    logic [GW:0]   res;
    int n;
    int e;
    int e0;
    n  = (1 << m) - 1;
    e0 = j % n;
    e  = e0;
    for (int i = 0; i <= GW; i++) c[i] = '0;
    c[0] = GW'(1);
    for (int k = 0; k < m; k++) begin
      if (k == 0 || e != e0) begin
        beta = gf_pow(e, m, prim);
        for (int i = GW; i >= 1; i--) c[i] = c[i-1] ^ gf_mul(c[i], beta, m, prim);
        c[0] = gf_mul(c[0], beta, m, prim);
        e = (2 * e) % n;
      end
    end
    for (int i = 0; i <= GW; i++) res[i] = c[i][0];
    return res;
  endfunction

  function automatic int poly_deg(input logic [GW:0] p);
    int d;
    d = 0;
    for (int i = 0; i <= GW; i++) if (p[i]) d = i;
    return d;
  endfunction

  // column c of the inverse basis map: v with sum_k v_k alpha^(j*k) = alpha^c
  function automatic logic [GW-1:0] inv_col(input int j, input int c, input int m, input int prim);
    logic [GW-1:0] tgt;
    logic [GW-1:0] acc;
    tgt = gf_pow(c, m, prim);
    for (int v = 0; v < (1 << m); v++) begin
      acc = '0;
      for (int k = 0; k < m; k++) if (((v >> k) & 1) == 1) acc = acc ^ gf_pow(j * k, m, prim);
      if (acc == tgt) return GW'(v);
    end
    return '0;
  endfunction
endpackage

// File: rtl/jsc_bt.sv
// Constant GF(2) matrix: forward map (sum v_k alpha^(J*k)) or its inverse.
module jsc_bt #(
  parameter int M    = 4,
  parameter int J    = 1,
  parameter int PRIM = 'h13,
  parameter bit INV  = 1'b0
) (
  input  logic [M-1:0] v,
  output logic [M-1:0] y
);
  logic [M-1:0] terms [M];

  for (genvar k = 0; k < M; k++) begin : g_col
    if (INV) begin : g_inv
      localparam logic [bch_pkg::GW-1:0] CK = bch_pkg::inv_col(J, k, M, PRIM);
      assign terms[k] = v[k] ? CK[M-1:0] : '0;
    end else begin : g_fwd
      localparam logic [bch_pkg::GW-1:0] CK = bch_pkg::gf_pow(J * k, M, PRIM);
      assign terms[k] = v[k] ? CK[M-1:0] : '0;
    end
  end

  always_comb begin
    y = '0;
    for (int k = 0; k < M; k++) y = y ^ terms[k];
  end
endmodule

// File: rtl/jsc_mpcn.sv
// P unrolled steps of r <- (r*x + b) mod poly; the polynomial is picked by phase.
module jsc_mpcn #(
  parameter int           M      = 4,
  parameter int           P      = 3,
  parameter logic [M:0]   POLY_S = '0,
  parameter logic [M:0]   POLY_Y = '0
) (
  input  logic [M-1:0]   start,
  input  logic [P-1:0]   bits,
  input  logic           use_syn,
  output logic [P*M-1:0] stages
);
  localparam int DS = bch_pkg::poly_deg((bch_pkg::GW+1)'(POLY_S));
  localparam int DY = bch_pkg::poly_deg((bch_pkg::GW+1)'(POLY_Y));

  logic [M:0]   pol;
  logic [M:0]   ext;
  logic [M-1:0] r;
  int           dg;

  always_comb begin
    pol = use_syn ? POLY_Y : POLY_S;
    dg  = use_syn ? DY : DS;
    r   = start;
    ext = '0;
    stages = '0;
    for (int s = 0; s < P; s++) begin
      ext = {r, bits[P-1-s]};
      if (ext[dg]) ext = ext ^ pol;
      r = ext[M-1:0];
      stages[s*M +: M] = r;
    end
  end
endmodule

// File: rtl/jsc_unit.sv
module jsc_unit #(
  parameter int M    = 4,
  parameter int N    = 15,
  parameter int T    = 2,
  parameter int P    = 3,
  parameter int PRIM = 'h13,
  localparam int NB  = (N + P - 1) / P,
  localparam int LW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_syn,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [P-1:0]      rx_bits,
  input  logic              lam_load,
  input  logic [T*M-1:0]    lam_coef,
  output logic              syn_valid,
  output logic [2*T*M-1:0]  syn_out,
  output logic              srch_valid,
  output logic [P-1:0]      srch_flag,
  output logic [P*LW-1:0]   srch_loc
);
  localparam int PAD = NB * P - N;
  localparam int CW  = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [P-1:0] FIRST_MASK = {P{1'b1}} >> PAD;

  logic [CW-1:0]  cnt;
  logic [CW-1:0]  tau;
  logic           busy;
  logic           beat;
  logic           lam_go;
  logic           first;
  logic [P-1:0]   bits_in;
  logic [M-1:0]   rem    [T];
  logic [M-1:0]   start  [T];
  logic [P*M-1:0] stg    [T];
  logic [M-1:0]   ibt_v  [T];
  logic [M-1:0]   s_odd  [T];
  logic [M-1:0]   ev     [P][T];
  logic [M-1:0]   s_all  [2*T+1];

  assign rx_ready   = mode_syn;
  assign beat       = rx_valid & mode_syn;
  assign lam_go     = lam_load & ~mode_syn;
  assign first      = (cnt == '0);
  assign srch_valid = busy & ~mode_syn;
  // received-bit injection gated off in the search phase
  assign bits_in    = rx_bits & {P{mode_syn}} & (first ? FIRST_MASK : {P{1'b1}});

  for (genvar jj = 0; jj < T; jj++) begin : g_row
    localparam logic [bch_pkg::GW:0] PS = bch_pkg::minpoly(jj + 1, M, PRIM);
    localparam logic [bch_pkg::GW:0] PY = bch_pkg::minpoly(2 * jj + 1, M, PRIM);

    assign start[jj] = (mode_syn && first) ? '0 : rem[jj];

    jsc_mpcn #(.M(M), .P(P), .POLY_S(PS[M:0]), .POLY_Y(PY[M:0])) u_net (
      .start(start[jj]), .bits(bits_in), .use_syn(mode_syn), .stages(stg[jj]));

    jsc_bt #(.M(M), .J(jj + 1), .PRIM(PRIM), .INV(1'b1)) u_ibt (
      .v(lam_coef[jj*M +: M]), .y(ibt_v[jj]));

    jsc_bt #(.M(M), .J(2 * jj + 1), .PRIM(PRIM), .INV(1'b0)) u_sbt (
      .v(rem[jj]), .y(s_odd[jj]));

    for (genvar r = 0; r < P; r++) begin : g_eval
      jsc_bt #(.M(M), .J(jj + 1), .PRIM(PRIM), .INV(1'b0)) u_cbt (
        .v(stg[jj][r*M +: M]), .y(ev[r][jj]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      tau       <= '0;
      busy      <= 1'b0;
      syn_valid <= 1'b0;
      for (int j = 0; j < T; j++) rem[j] <= '0;
    end else begin
      syn_valid <= beat && (cnt == CW'(NB - 1));
      if (beat) cnt <= (cnt == CW'(NB - 1)) ? '0 : cnt + 1'b1;
      else if (lam_go) cnt <= '0;

      if (mode_syn) busy <= 1'b0;
      else if (lam_load) begin
        busy <= 1'b1;
        tau  <= '0;
      end else if (busy) begin
        if (tau == CW'(NB - 1)) busy <= 1'b0;
        tau <= tau + 1'b1;
      end

      for (int j = 0; j < T; j++) begin
        if (lam_go) rem[j] <= ibt_v[j];
        else if (beat || srch_valid) rem[j] <= stg[j][(P-1)*M +: M];
      end
    end
  end

  // root test per row: 1 + sum of transformed terms
  always_comb begin
    logic [M-1:0] acc;
    int idx;
    srch_flag = '0;
    srch_loc  = '0;
    for (int r = 0; r < P; r++) begin
      acc = M'(1);
      for (int j = 0; j < T; j++) acc = acc ^ ev[r][j];
      idx = r + 1 + P * int'(tau);
      if (idx <= N) begin
        srch_flag[r] = srch_valid && (acc == '0);
        srch_loc[r*LW +: LW] = LW'(N - idx);
      end
    end
  end

  // odd syndromes from the rows, even ones by squaring
  always_comb begin
    s_all[0] = '0;
    syn_out  = '0;
    for (int i = 1; i <= 2 * T; i++) begin
      if (i % 2 == 1) s_all[i] = s_odd[(i-1)/2];
      else s_all[i] = M'(bch_pkg::gf_mul(bch_pkg::GW'(s_all[i/2]), bch_pkg::GW'(s_all[i/2]), M, PRIM));
      syn_out[(i-1)*M +: M] = s_all[i];
    end
  end
endmodule

// File: rtl/jsc_unit_chk.sv
module jsc_unit_chk #(
  parameter int M  = 4,
  parameter int N  = 15,
  parameter int T  = 2,
  parameter int P  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_syn,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             lam_load,
  input logic             syn_valid,
  input logic [2*T*M-1:0] syn_out,
  input logic             srch_valid,
  input logic [P-1:0]     srch_flag
);
  localparam int NB = (N + P - 1) / P;
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else begin
      run_len <= srch_valid ? run_len + 1 : 0;
      assert_len_R8: assert (!srch_valid || run_len < NB)
        else $error("search ran past %0d cycles", NB);
    end
  end

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid |=> !syn_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_syn && !(rx_valid && rx_ready)) |=> $stable(syn_out));

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    srch_valid |-> !rx_ready);

  assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lam_load && !mode_syn) |=> (srch_valid || mode_syn));

  assert_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|srch_flag) |-> srch_valid);

  assert_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(srch_flag) <= T);
endmodule

bind jsc_unit jsc_unit_chk #(.M(M), .N(N), .T(T), .P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_syn(mode_syn), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .lam_load(lam_load), .syn_valid(syn_valid),
  .syn_out(syn_out), .srch_valid(srch_valid), .srch_flag(srch_flag));

// File: tb/sim_jsc_unit.sv
`timescale 1ns/1ps
module sim_jsc_unit;
  localparam int M = 4, N = 15, T = 2, P = 3;
  localparam int NB = 5, LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_syn = 1'b1, rx_valid = 1'b0, lam_load = 1'b0;
  logic [P-1:0] rx_bits = '0;
  logic [T*M-1:0] lam_coef = '0;
  logic rx_ready, syn_valid, srch_valid;
  logic [2*T*M-1:0] syn_out;
  logic [P-1:0] srch_flag;
  logic [P*LW-1:0] srch_loc;

  int checks = 0, errors = 0;
  int apow [15];

  always #4 clk = ~clk;

  jsc_unit u0 (.clk(clk), .rst_n(rst_n), .mode_syn(mode_syn), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_bits(rx_bits), .lam_load(lam_load), .lam_coef(lam_coef),
    .syn_valid(syn_valid), .syn_out(syn_out), .srch_valid(srch_valid),
    .srch_flag(srch_flag), .srch_loc(srch_loc));

  // stimulus: {message[6:0], error mask[14:0]}
  localparam logic [21:0] VEC [6] = '{
    {7'h5A, 15'h0000}, {7'h13, 15'h0001}, {7'h7F, 15'h4000},
    {7'h01, 15'h0210}, {7'h66, 15'h4001}, {7'h2C, 15'h0108}};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*T*M-1:0] ref_syn(input logic [14:0] w);
    logic [2*T*M-1:0] s;
    int v;
    s = '0;
    for (int i = 1; i <= 2*T; i++) begin
      v = 0;
      for (int k = 0; k < N; k++) if (w[k]) v = v ^ apow[(i*k) % 15];
      s[(i-1)*M +: M] = M'(v);
    end
    return s;
  endfunction

  task automatic send_word(input logic [14:0] w, input bit gap);
    logic [2*T*M-1:0] exp;
    exp = ref_syn(w);
    for (int b = 0; b < NB; b++) begin
      if (gap && b == 2) begin
        @(negedge clk);
        mode_syn = 1'b0; rx_valid = 1'b1; rx_bits = '1;
        chk("R2 ready low", 64'(rx_ready), 64'd0);
      end
      @(negedge clk);
      if (b == NB-1) chk("R4 no early valid", 64'(syn_valid), 64'd0);
      mode_syn = 1'b1; rx_valid = 1'b1;
      for (int s = 0; s < P; s++) rx_bits[P-1-s] = w[N-1-P*b-s];
    end
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R4 valid", 64'(syn_valid), 64'd1);
    chk("R3 R5 R6 syndromes", 64'(syn_out), 64'(exp));
    @(negedge clk);
    chk("R4 pulse end", 64'(syn_valid), 64'd0);
    chk("R7 hold", 64'(syn_out), 64'(exp));
  endtask

  task automatic search(input logic [14:0] emask);
    int pos [2];
    int cnt;
    int l1, l2, idx;
    logic [P-1:0] ef;
    logic [P*LW-1:0] el;
    cnt = 0; pos[0] = 0; pos[1] = 0;
    for (int k = 0; k < N; k++) if (emask[k] && cnt < 2) begin pos[cnt] = k; cnt++; end
    l1 = (cnt >= 1) ? (apow[pos[0]] ^ ((cnt == 2) ? apow[pos[1]] : 0)) : 0;
    l2 = (cnt == 2) ? apow[(pos[0] + pos[1]) % 15] : 0;
    @(negedge clk);
    mode_syn = 1'b0; lam_load = 1'b1; lam_coef = {M'(l2), M'(l1)};
    @(negedge clk);
    lam_load = 1'b0;
    for (int tau = 0; tau < NB; tau++) begin
      ef = '0; el = '0;
      for (int r = 0; r < P; r++) begin
        idx = r + 1 + P*tau;
        if (idx <= N) begin
          ef[r] = emask[N-idx];
          el[r*LW +: LW] = LW'(N - idx);
        end
      end
      chk("R8 search valid", 64'(srch_valid), 64'd1);
      chk("R9 flags", 64'(srch_flag), 64'(ef));
      chk("R9 locations", 64'(srch_loc), 64'(el));
      chk("R11 flag count", 64'($countones(srch_flag) <= T), 64'd1);
      @(negedge clk);
    end
    chk("R8 search end", 64'(srch_valid), 64'd0);
    mode_syn = 1'b1;
  endtask

  initial begin : watchdog
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int a;
    logic [14:0] cw;
    logic [2*T*M-1:0] held;
    a = 1;
    for (int i = 0; i < 15; i++) begin
      apow[i] = a;
      a = a << 1;
      if (a & 16) a = a ^ 'h13;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 syn_valid", 64'(syn_valid), 64'd0);
    chk("R1 srch_valid", 64'(srch_valid), 64'd0);
    chk("R1 flags", 64'(srch_flag), 64'd0);
    chk("R2 ready", 64'(rx_ready), 64'd1);

    for (int v = 0; v < 6; v++) begin
      cw = '0;
      for (int i = 0; i < 7; i++) if (VEC[v][15+i]) cw = cw ^ (15'h1D1 << i);
      send_word(cw ^ VEC[v][14:0], v == 3);
      search(VEC[v][14:0]);
    end

    // R10: load request in the syndrome phase
    send_word(15'h2461, 1'b0);
    held = syn_out;
    @(negedge clk);
    lam_load = 1'b1; lam_coef = 8'h35;
    @(negedge clk);
    lam_load = 1'b0;
    chk("R10 no search", 64'(srch_valid), 64'd0);
    chk("R10 syndromes kept", 64'(syn_out), 64'(held));
    @(negedge clk);
    chk("R10 no flags", 64'(srch_flag), 64'd0);

    // R6: word right after a word with no search between
    send_word(15'h0003, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule